// File: doc/BRIEF.md
# Warm/Cold Reset Arbiter with Memory-Safe Handshake

This block decides, for each incoming reset request, whether the chip receives a warm reset or a cold reset. Three requesters are each gated by a 4-bit redundant field: a primary watchdog, a thermal sensor and a secondary watchdog. A core-lockup requester is gated by a single enable bit. A hard cold request input is never gated. A global warm enable selects the policy. When the enable is clear, every gated request becomes a cold reset.

A warm reset is not issued at once. The block first raises a request to the memory controller, asking it to put DRAM into a safe state, and then waits for that controller's acknowledge. A 2-bit bypass code limits the wait, counted in slow 32 kHz ticks. The tick arrives as a one-cycle strobe already synchronised to the main clock. If the limit runs out before the acknowledge, the block escalates to a cold reset. A hard cold request during the wait cuts the wait short. Each outcome is a one-cycle pulse on the warm or the cold output.

Top module: `warm_cold_rst_arb`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `mem_safe_req`, `warm_rst` and `cold_rst` are all low. Asserting `rst` during a wait abandons that wait.
- R2: Each 4-bit gate field blocks its requester only when it holds 4'h5. The enable codes are 4'hA for both watchdogs and 4'h2 for the thermal sensor. Any other value is also treated as enabled, so that a corrupted field still lets the reset through.
- R3: The lockup requester has an effect only when `lockup_en` is 1.
- R4: With `warm_en` = 0, a gated request produces a `cold_rst` pulse in the cycle after the request is sampled, and `mem_safe_req` stays low.
- R5: With `warm_en` = 1, a gated request raises `mem_safe_req` in the cycle after it is sampled. `mem_safe_req` stays high until an acknowledge, an expiry or a cold preemption ends the wait.
- R6: An acknowledge sampled during the wait gives one `warm_rst` pulse in the next cycle, and `mem_safe_req` drops in that same cycle.
- R7: Bypass codes 1, 2 and 3 allow 16, 32 and 64 ticks. Only ticks seen during the wait are counted. Once the last allowed tick is sampled without an acknowledge, `cold_rst` pulses one cycle later.
- R8: With bypass code 0 the wait has no limit, however many ticks arrive.
- R9: `hard_cold_req` sampled during the wait ends it, and `cold_rst` pulses in the next cycle.
- R10: `warm_rst` and `cold_rst` are single-cycle pulses and are never high together. A warm-capable request and `hard_cold_req` in the same cycle yield a cold reset.
- R11: When an acknowledge and count expiry occur in the same cycle, the acknowledge wins and the outcome is a warm reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| wdog_req | input | 1 | Primary watchdog reset request |
| therm_req | input | 1 | Thermal sensor reset request |
| wdog2_req | input | 1 | Secondary watchdog reset request |
| lockup_req | input | 1 | Core lockup reset request |
| hard_cold_req | input | 1 | Ungated request that is always served cold |
| wdog_fld | input | 4 | Gate field for the primary watchdog |
| therm_fld | input | 4 | Gate field for the thermal sensor |
| wdog2_fld | input | 4 | Gate field for the secondary watchdog |
| lockup_en | input | 1 | Enable for the lockup requester |
| warm_en | input | 1 | Global warm enable; when 0, all requests are served cold |
| bypass_sel | input | 2 | Acknowledge wait limit code |
| slow_tick | input | 1 | One-cycle slow-clock strobe |
| mem_ack | input | 1 | Memory controller acknowledge that DRAM is safe |
| mem_safe_req | output | 1 | Request to the memory controller, held during the wait |
| warm_rst | output | 1 | Warm reset pulse |
| cold_rst | output | 1 | Cold reset pulse |

## Verification
All results are due exactly one clock edge after the input that causes them is sampled:
- a request moves `mem_safe_req` or `cold_rst`;
- an acknowledge or a hard cold request ends the wait;
- expiry takes effect one edge after the final tick lands in the counter.

The bench drives inputs and samples outputs on falling edges. Each request, tick or acknowledge is held for exactly one rising edge and read back at the next falling edge. Around each timeout the bench checks that the wait is still open after the last tick but one, and again right after the last tick. It then expects the cold pulse exactly one cycle later.

// File: rtl/wcr_pkg.sv
package wcr_pkg;

    localparam int NUM_CODED = 3;
    localparam int FLD_W     = 4;

    localparam logic [FLD_W-1:0] FLD_MASKED   = 4'h5;
    localparam logic [FLD_W-1:0] FLD_WDOG_ON  = 4'hA;
    localparam logic [FLD_W-1:0] FLD_THERM_ON = 4'h2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_ACK,
        ST_WARM,
        ST_COLD
    } arb_state_e;

    typedef struct packed {
        logic warm;
        logic cold;
    } req_s;

    // Only the explicit masked code blocks; anything else passes (fail safe).
    function automatic logic field_enables(input logic [FLD_W-1:0] fld);
        return fld != FLD_MASKED;
    endfunction

endpackage

// File: rtl/wcr_src_gate.sv
module wcr_src_gate
    import wcr_pkg::*;
#(
    parameter int N_SRC = NUM_CODED
) (
    input  logic [N_SRC-1:0]            coded_req,
    input  logic [N_SRC-1:0][FLD_W-1:0] coded_fld,
    input  logic                        lockup_req,
    input  logic                        lockup_en,
    input  logic                        hard_cold_req,
    input  logic                        warm_en,
    output req_s                        req
);

    logic [N_SRC-1:0] gated;
    logic             any_warm_capable;

    for (genvar g = 0; g < N_SRC; g++) begin : g_gate
        assign gated[g] = coded_req[g] & field_enables(coded_fld[g]);
    end

    assign any_warm_capable = (|gated) | (lockup_req & lockup_en);

    always_comb begin
        req.cold = hard_cold_req | (any_warm_capable & ~warm_en);
        req.warm = any_warm_capable & warm_en;
    end

endmodule

// File: rtl/wcr_bypass_timer.sv
module wcr_bypass_timer #(
    parameter int BASE_TICKS = 16,
    parameter int SEL_W      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             expired
);

    localparam int MAX_TICKS = BASE_TICKS << ((1 << SEL_W) - 2);
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    always_comb begin
        if (sel == '0)
            limit = '0;
        else
            limit = CNT_W'(BASE_TICKS) << (sel - SEL_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (tick && cnt != CNT_W'(MAX_TICKS))
            cnt <= cnt + CNT_W'(1);
    end

    assign expired = (sel != '0) && (cnt >= limit);

endmodule

// File: rtl/wcr_arb_fsm.sv
module wcr_arb_fsm
    import wcr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  req_s req,
    input  logic mem_ack,
    input  logic expired,
    output logic waiting,
    output logic warm_pulse,
    output logic cold_pulse
);

    arb_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req.cold)
                    state_nx = ST_COLD;
                else if (req.warm)
                    state_nx = ST_WAIT_ACK;
            end
            ST_WAIT_ACK: begin
                if (req.cold)
                    state_nx = ST_COLD;
                else if (mem_ack)
                    state_nx = ST_WARM;
                else if (expired)
                    state_nx = ST_COLD;
            end
            ST_WARM: state_nx = ST_IDLE;
            ST_COLD: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    assign waiting    = (state == ST_WAIT_ACK);
    assign warm_pulse = (state == ST_WARM);
    assign cold_pulse = (state == ST_COLD);

endmodule

// File: rtl/warm_cold_rst_arb.sv
module warm_cold_rst_arb
    import wcr_pkg::*;
#(
    parameter int BASE_TICKS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wdog_req,
    input  logic       therm_req,
    input  logic       wdog2_req,
    input  logic       lockup_req,
    input  logic       hard_cold_req,
    input  logic [3:0] wdog_fld,
    input  logic [3:0] therm_fld,
    input  logic [3:0] wdog2_fld,
    input  logic       lockup_en,
    input  logic       warm_en,
    input  logic [1:0] bypass_sel,
    input  logic       slow_tick,
    input  logic       mem_ack,
    output logic       mem_safe_req,
    output logic       warm_rst,
    output logic       cold_rst
);

    logic [NUM_CODED-1:0]            coded_req;
    logic [NUM_CODED-1:0][FLD_W-1:0] coded_fld;
    req_s                            req;
    logic                            expired;
    logic                            waiting;

    assign coded_req = {wdog2_req, therm_req, wdog_req};
    assign coded_fld = {wdog2_fld, therm_fld, wdog_fld};

    wcr_src_gate #(.N_SRC(NUM_CODED)) u_gate (
        .coded_req     (coded_req),
        .coded_fld     (coded_fld),
        .lockup_req    (lockup_req),
        .lockup_en     (lockup_en),
        .hard_cold_req (hard_cold_req),
        .warm_en       (warm_en),
        .req           (req)
    );

    wcr_bypass_timer #(.BASE_TICKS(BASE_TICKS), .SEL_W(2)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (waiting),
        .tick    (slow_tick),
        .sel     (bypass_sel),
        .expired (expired)
    );

    wcr_arb_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .mem_ack    (mem_ack),
        .expired    (expired),
        .waiting    (waiting),
        .warm_pulse (warm_rst),
        .cold_pulse (cold_rst)
    );

    assign mem_safe_req = waiting;

endmodule

// File: rtl/wcr_arb_chk.sv
module wcr_arb_chk (
    input logic       clk,
    input logic       rst,
    input logic       hard_cold_req,
    input logic       warm_en,
    input logic [1:0] bypass_sel,
    input logic       mem_ack,
    input logic       mem_safe_req,
    input logic       warm_rst,
    input logic       cold_rst
);

    // R10
    never_both_chk: assert property (@(posedge clk) disable iff (rst)
        !(warm_rst && cold_rst));

    // R10
    warm_single_chk: assert property (@(posedge clk) disable iff (rst)
        warm_rst |=> !warm_rst);

    // R10
    cold_single_chk: assert property (@(posedge clk) disable iff (rst)
        cold_rst |=> !cold_rst);

    // R6
    warm_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_safe_req && mem_ack && !hard_cold_req) |=> (warm_rst && !mem_safe_req));

    // R9
    preempt_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_safe_req && hard_cold_req) |=> cold_rst);

    // R8
    no_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_safe_req && !mem_ack && !hard_cold_req && warm_en && bypass_sel == 2'd0)
        |=> mem_safe_req);

    // R5
    wait_excl_chk: assert property (@(posedge clk) disable iff (rst)
        mem_safe_req |-> (!warm_rst && !cold_rst));

endmodule

bind warm_cold_rst_arb wcr_arb_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .hard_cold_req (hard_cold_req),
    .warm_en       (warm_en),
    .bypass_sel    (bypass_sel),
    .mem_ack       (mem_ack),
    .mem_safe_req  (mem_safe_req),
    .warm_rst      (warm_rst),
    .cold_rst      (cold_rst)
);

// File: tb/warm_cold_rst_arb_tb.sv
module warm_cold_rst_arb_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wdog_req = 0, therm_req = 0, wdog2_req = 0, lockup_req = 0, hard_cold_req = 0;
    logic [3:0] wdog_fld = 4'hA, therm_fld = 4'h2, wdog2_fld = 4'hA;
    logic       lockup_en = 1'b1, warm_en = 1'b1;
    logic [1:0] bypass_sel = 2'd1;
    logic       slow_tick = 1'b0, mem_ack = 1'b0;
    logic       mem_safe_req, warm_rst, cold_rst;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    warm_cold_rst_arb u_dut (
        .clk(clk), .rst(rst),
        .wdog_req(wdog_req), .therm_req(therm_req), .wdog2_req(wdog2_req),
        .lockup_req(lockup_req), .hard_cold_req(hard_cold_req),
        .wdog_fld(wdog_fld), .therm_fld(therm_fld), .wdog2_fld(wdog2_fld),
        .lockup_en(lockup_en), .warm_en(warm_en), .bypass_sel(bypass_sel),
        .slow_tick(slow_tick), .mem_ack(mem_ack),
        .mem_safe_req(mem_safe_req), .warm_rst(warm_rst), .cold_rst(cold_rst)
    );

    // Compares {mem_safe_req, warm_rst, cold_rst}.
    task automatic chk(input string tag, input logic [2:0] exp);
        logic [2:0] got;
        got = {mem_safe_req, warm_rst, cold_rst};
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {req,warm,cold} got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // Hold one requester for exactly one rising edge; returns on the next falling edge.
    task automatic raise(input int which);
        case (which)
            0: wdog_req = 1'b1;
            1: therm_req = 1'b1;
            2: wdog2_req = 1'b1;
            3: lockup_req = 1'b1;
            default: hard_cold_req = 1'b1;
        endcase
        @(negedge clk);
        wdog_req = 0; therm_req = 0; wdog2_req = 0; lockup_req = 0; hard_cold_req = 0;
    endtask

    task automatic tick_once();
        slow_tick = 1'b1;
        @(negedge clk);
        slow_tick = 1'b0;
    endtask

    task automatic ack_and_finish(input string tag);
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        chk(tag, 3'b010);
        @(negedge clk);
        chk(tag, 3'b000);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 in reset", 3'b000);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", 3'b000);
        raise(0);
        chk("R1 wait opened", 3'b100);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset abandons wait", 3'b000);
        @(negedge clk);
        chk("R1 idle after reset", 3'b000);
    endtask

    task automatic t_cold_mode();
        warm_en = 1'b0;
        raise(1);
        chk("R4 cold when warm disabled", 3'b001);
        @(negedge clk);
        chk("R4 pulse ended", 3'b000);
        warm_en = 1'b1;
    endtask

    task automatic t_masks();
        wdog_fld = 4'h5;  raise(0); chk("R2 wdog masked", 3'b000);
        @(negedge clk);   chk("R2 wdog masked later", 3'b000);
        wdog_fld = 4'hA;
        therm_fld = 4'h5; raise(1); chk("R2 therm masked", 3'b000);
        therm_fld = 4'h2;
        wdog2_fld = 4'h5; raise(2); chk("R2 wdog2 masked", 3'b000);
        wdog2_fld = 4'hA; raise(2); chk("R2 wdog2 enabled", 3'b100);
        ack_and_finish("R2 wdog2 warm");
        raise(1); chk("R2 therm enabled 0x2", 3'b100);
        ack_and_finish("R2 therm warm");
        wdog_fld = 4'h3;  raise(0); chk("R2 corrupt field fails safe", 3'b100);
        ack_and_finish("R2 corrupt field warm");
        wdog_fld = 4'hA;
    endtask

    task automatic t_lockup();
        lockup_en = 1'b0; raise(3); chk("R3 lockup disabled", 3'b000);
        @(negedge clk);   chk("R3 lockup disabled later", 3'b000);
        lockup_en = 1'b1; raise(3); chk("R3 lockup enabled", 3'b100);
        ack_and_finish("R3 lockup warm");
    endtask

    task automatic t_ack();
        raise(0);
        chk("R5 wait opened", 3'b100);
        repeat (4) @(negedge clk);
        chk("R5 wait held", 3'b100);
        ack_and_finish("R6 warm on ack");
    endtask

    task automatic t_timeout(input logic [1:0] sel, input int lim);
        bypass_sel = sel;
        repeat (5) begin tick_once(); @(negedge clk); end   // idle ticks must not count
        raise(1);
        chk("R7 wait opened", 3'b100);
        for (int i = 0; i < lim - 1; i++) begin
            tick_once();
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        chk("R7 still waiting one tick short", 3'b100);
        tick_once();
        chk("R7 last tick counted", 3'b100);
        @(negedge clk);
        chk("R7 expiry gives cold", 3'b001);
        @(negedge clk);
        chk("R7 back to idle", 3'b000);
    endtask

    task automatic t_no_limit();
        bypass_sel = 2'd0;
        raise(2);
        for (int i = 0; i < 80; i++) begin
            tick_once();
            @(negedge clk);
        end
        chk("R8 no limit after 80 ticks", 3'b100);
        ack_and_finish("R8 warm after long wait");
    endtask

    task automatic t_preempt();
        bypass_sel = 2'd1;
        raise(0);
        repeat (3) begin tick_once(); @(negedge clk); end
        chk("R9 waiting before preempt", 3'b100);
        raise(4);
        chk("R9 preempted to cold", 3'b001);
        @(negedge clk);
        chk("R9 back to idle", 3'b000);
    endtask

    task automatic t_both();
        wdog_req = 1'b1;
        hard_cold_req = 1'b1;
        @(negedge clk);
        wdog_req = 1'b0;
        hard_cold_req = 1'b0;
        chk("R10 simultaneous gives cold", 3'b001);
        @(negedge clk);
        chk("R10 single pulse", 3'b000);
    endtask

    task automatic t_tie();
        bypass_sel = 2'd1;
        raise(0);
        for (int i = 0; i < 16; i++) begin
            tick_once();
            if (i != 15) @(negedge clk);
        end
        chk("R11 expired but not yet acted", 3'b100);
        ack_and_finish("R11 ack wins over expiry");
    endtask

    initial begin
        t_reset();
        t_cold_mode();
        t_masks();
        t_lockup();
        t_ack();
        t_timeout(2'd1, 16);
        t_timeout(2'd2, 32);
        t_timeout(2'd3, 64);
        t_no_limit();
        t_preempt();
        t_both();
        t_tie();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, got no completion expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule